// File: doc/BRIEF.md
# Burst Master Abort and Retry Control

This block sequences the words of one burst for a bus master. An internal engine asks for a burst of a given length. The controller then presents a word index and a data-valid flag. It steps to the next word only when the target signals that it is ready, using an active-low ready input. The target can cancel the word in flight with an active-low abort input. The controller then drops that word and holds its index. It withdraws data-valid for as long as abort stays low. When abort is released, it presents the same word again. The burst never rewinds to its first word.

Ready and abort are sampled in one of two ways. In normal mode they pass through one register before the sequencer acts on them. In early mode the sequencer acts on the pin values at the clock edge itself, which is one clock sooner. The mode is captured when a burst starts. When the last word has been accepted, the controller issues a single done pulse and returns to idle. Address generation, arbitration and the data path are handled outside this block.

Top module: `burst_master_ctl`

## Requirements
- R1: While `rst` is high on a clock edge, the block goes idle after that edge: `busy`, `word_vld` and `done` are 0, and `word_idx` is 0.
- R2: In idle, `req` with `req_len` from 1 to MAX_LEN starts a burst. After that edge, `busy`=1, `word_vld`=1 and `word_idx`=0. A request with `req_len`=0 is ignored. A request made while busy is ignored, and the length of the running burst does not change.
- R3: A word is accepted on an edge where the sampled `rdy_n` is 0 and the sampled `abt_n` is 1, provided data-valid is high. Acceptance raises `word_idx` by exactly 1.
- R4: While the sampled `rdy_n` is 1, `word_idx` does not change.
- R5: When the sampled `abt_n` is 0, `word_vld` is 0 after that edge and `word_idx` stays on the aborted word.
- R6: While the sampled `abt_n` is 0, a low `rdy_n` neither advances `word_idx` nor completes the burst.
- R7: On the first edge where `abt_n` is sampled high again, `word_vld` returns to 1 with the same `word_idx`. No word is accepted on that edge.
- R8: With `early_mode`=1, the pin values at an edge act on that edge. With `early_mode`=0, they act one edge later.
- R9: `early_mode` is captured when a burst starts. Changes to it during the burst have no effect on sampling.
- R10: Acceptance of word `req_len`-1 makes `done`=1 for exactly one cycle. On that same edge `busy` and `word_vld` go to 0 and `word_idx` goes to 0.
- R11: No `done` is produced while the last word is aborted. `done` follows only after that word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| early_mode | input | 1 | 1 = early sampling, 0 = normal (registered) sampling |
| req | input | 1 | Burst request from the internal engine |
| req_len | input | LEN_W | Number of words in the requested burst (1..MAX_LEN) |
| rdy_n | input | 1 | Target ready, active low |
| abt_n | input | 1 | Abort of the current word, active low; held high when unused |
| busy | output | 1 | A burst is in progress |
| word_vld | output | 1 | The word at `word_idx` is being offered |
| word_idx | output | IDX_W | Index of the current word within the burst |
| done | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
The hardest case to reach is an abort on the final word while ready is held low. If the abort were not given priority, that single edge would complete the burst. The stimulus runs an early-mode burst up to its last index, then drives abort and ready low together for several cycles. It checks that neither done nor an index change appears. It then releases abort and checks for one re-presentation cycle before done. A second hard case is a change of the mode bit in the middle of a burst. This is driven on the same cycle as ready, so the one-cycle lag of normal sampling shows whether the captured mode was used.

// File: rtl/burst_ctl_pkg.sv
package burst_ctl_pkg;

    typedef struct packed {
        logic rdy_n;
        logic abt_n;
    } hs_t;

    localparam hs_t HS_QUIET = '{rdy_n: 1'b1, abt_n: 1'b1};

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } bst_t;

    function automatic logic hs_go(input hs_t s);
        return (!s.rdy_n) && s.abt_n;
    endfunction

    function automatic logic hs_cancel(input hs_t s);
        return !s.abt_n;
    endfunction

endpackage

// File: rtl/bm_hs_sampler.sv
module bm_hs_sampler
    import burst_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic early,
    input  hs_t  pins,
    output hs_t  smp
);
    hs_t pins_q;

    always_ff @(posedge clk) begin
        if (rst) pins_q <= HS_QUIET;
        else     pins_q <= pins;
    end

    // early: act on the edge itself; normal: act on last edge's capture
    assign smp = early ? pins : pins_q;
endmodule

// File: rtl/bm_word_seq.sv
module bm_word_seq
    import burst_ctl_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int LEN_W = 5
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [LEN_W-1:0] req_len,
    input  logic             early_in,
    input  hs_t              smp,
    output logic             mode_q,
    output logic             busy,
    output logic             vld,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    bst_t             st;
    logic [IDX_W-1:0] last_idx;
    logic             hold;
    logic             start;

    assign start = (st == ST_IDLE) && req && (req_len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
            hold     <= 1'b0;
            done     <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st       <= ST_XFER;
                        idx      <= '0;
                        last_idx <= IDX_W'(req_len - LEN_W'(1));
                        hold     <= 1'b0;
                        mode_q   <= early_in;
                    end
                end
                ST_XFER: begin
                    if (hs_cancel(smp)) begin
                        hold <= 1'b1;
                    end else if (hold) begin
                        hold <= 1'b0;
                    end else if (hs_go(smp)) begin
                        if (idx == last_idx) begin
                            st   <= ST_IDLE;
                            idx  <= '0;
                            done <= 1'b1;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st == ST_XFER);
    assign vld  = busy && !hold;
endmodule

// File: rtl/burst_master_ctl.sv
module burst_master_ctl
    import burst_ctl_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             early_mode,
    input  logic             req,
    input  logic [LEN_W-1:0] req_len,
    input  logic             rdy_n,
    input  logic             abt_n,
    output logic             busy,
    output logic             word_vld,
    output logic [IDX_W-1:0] word_idx,
    output logic             done
);
    hs_t  pins;
    hs_t  smp;
    logic mode_q;

    assign pins = '{rdy_n: rdy_n, abt_n: abt_n};

    bm_hs_sampler u_smp (
        .clk   (clk),
        .rst   (rst),
        .early (mode_q),
        .pins  (pins),
        .smp   (smp)
    );

    bm_word_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_len  (req_len),
        .early_in (early_mode),
        .smp      (smp),
        .mode_q   (mode_q),
        .busy     (busy),
        .vld      (word_vld),
        .idx      (word_idx),
        .done     (done)
    );
endmodule

// File: rtl/bm_chk.sv
module bm_chk #(
    parameter int IDX_W = 4
)(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             word_vld,
    input logic [IDX_W-1:0] word_idx,
    input logic             done
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy && !word_vld && !done && word_idx == '0)); // R1

    AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !word_vld); // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst))
        |-> (word_idx == $past(word_idx) || word_idx == IDX_W'($past(word_idx) + 1'b1))); // R3

    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
        (busy && !word_vld) |=> (busy && word_idx == $past(word_idx))); // R5

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && word_idx == '0)); // R10
endmodule

bind burst_master_ctl bm_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .word_vld (word_vld),
    .word_idx (word_idx),
    .done     (done)
);

// File: tb/sim_burst_master_ctl.sv
`timescale 1ns/1ps
module sim_burst_master_ctl;
    localparam int MAX_LEN = 16;
    localparam int IDX_W   = 4;
    localparam int LEN_W   = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             early_mode = 1'b1;
    logic             req = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             rdy_n = 1'b1;
    logic             abt_n = 1'b1;
    logic             busy, word_vld, done;
    logic [IDX_W-1:0] word_idx;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    burst_master_ctl #(.MAX_LEN(MAX_LEN)) u0 (
        .clk(clk), .rst(rst), .early_mode(early_mode), .req(req),
        .req_len(req_len), .rdy_n(rdy_n), .abt_n(abt_n),
        .busy(busy), .word_vld(word_vld), .word_idx(word_idx), .done(done)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic kick(input int len, input bit early);
        early_mode = early;
        req_len    = LEN_W'(len);
        req        = 1'b1;
        step();
        req        = 1'b0;
    endtask

    task automatic drain();
        abt_n = 1'b1;
        rdy_n = 1'b0;
        for (int i = 0; i < 40 && busy; i++) step();
        rdy_n = 1'b1;
        step(2);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 busy", busy, 0);
        chk("R1 vld", word_vld, 0);
        chk("R1 done", done, 0);
        chk("R1 idx", word_idx, 0);
        rst = 1'b0;
        step();
    endtask

    task automatic t_start();
        kick(0, 1'b1);
        chk("R2 zero length ignored", busy, 0);
        kick(3, 1'b1);
        chk("R2 busy", busy, 1);
        chk("R2 vld", word_vld, 1);
        chk("R2 idx", word_idx, 0);
        req_len = LEN_W'(5);
        req = 1'b1;
        step();
        req = 1'b0;
        rdy_n = 1'b0;
        step(2);
        chk("R3 idx after two accepts", word_idx, 2);
        step();
        chk("R2 len kept at 3, done", done, 1);
        chk("R10 busy low", busy, 0);
        chk("R10 vld low", word_vld, 0);
        chk("R10 idx zero", word_idx, 0);
        rdy_n = 1'b1;
        step();
        chk("R10 done one cycle", done, 0);
    endtask

    task automatic t_ready_high();
        kick(4, 1'b1);
        rdy_n = 1'b0;
        step();
        chk("R3 idx 1", word_idx, 1);
        rdy_n = 1'b1;
        step(3);
        chk("R4 idx held", word_idx, 1);
        chk("R4 still busy", busy, 1);
        drain();
    endtask

    task automatic t_normal();
        kick(4, 1'b0);
        rdy_n = 1'b0;
        step();
        chk("R8 normal lag idx", word_idx, 0);
        step();
        chk("R8 normal idx 1", word_idx, 1);
        rdy_n = 1'b1;
        step();
        chk("R8 normal trailing accept", word_idx, 2);
        step();
        chk("R8 normal settles", word_idx, 2);
        drain();
    endtask

    task automatic t_mode_latch();
        kick(3, 1'b0);
        early_mode = 1'b1;
        rdy_n = 1'b0;
        step();
        chk("R9 mode change ignored", word_idx, 0);
        step();
        chk("R9 normal path used", word_idx, 1);
        drain();
    endtask

    task automatic t_abort();
        kick(4, 1'b1);
        rdy_n = 1'b0;
        step();
        chk("R3 idx 1 before abort", word_idx, 1);
        abt_n = 1'b0;
        step();
        chk("R5 vld dropped", word_vld, 0);
        chk("R5 idx held", word_idx, 1);
        step(2);
        chk("R6 ready ignored", word_idx, 1);
        abt_n = 1'b1;
        step();
        chk("R7 vld back", word_vld, 1);
        chk("R7 same word", word_idx, 1);
        step();
        chk("R7 resumes from aborted word", word_idx, 2);
        drain();
    endtask

    task automatic t_abort_last();
        kick(2, 1'b1);
        rdy_n = 1'b0;
        step();
        chk("R3 at last word", word_idx, 1);
        abt_n = 1'b0;
        step();
        chk("R11 no done on abort", done, 0);
        step(2);
        chk("R11 no done while held", done, 0);
        chk("R11 still busy", busy, 1);
        abt_n = 1'b1;
        step();
        chk("R11 re-presented", word_vld, 1);
        chk("R11 no done yet", done, 0);
        step();
        chk("R11 done after accept", done, 1);
        rdy_n = 1'b1;
        step();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_start();
        t_ready_high();
        t_normal();
        t_mode_latch();
        t_abort();
        t_abort_last();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule